// File: doc/BRIEF.md
# Smart Card Character Engine

This block moves 8-bit characters in both directions over a single open-drain smart card data line, one direction at a time. A character is a low start bit, eight data bits with the least significant bit first, and a parity bit: 10 elementary time units (etu) in all. A guard period follows in which the line is released. The etu length is picked from four base clock counts by a 2-bit selector. The block never drives the line high. It only pulls the line low or releases it, and it senses the resolved level on a separate input.

Outside block mode, a receiver that finds a parity error pulls the line low during the guard time. A transmitter that sees that low level sends the same character again. In block mode, no error pulse is driven and none is honoured, and a parity error only raises the error flag. A second mode moves the transmit-end point earlier and hands control of the card clock enable to an input.

Top module: `sc_char_engine`

## Requirements
- R1: `cfg_cps` sets the etu length in base clock cycles: 2'b00 gives 32, 2'b01 gives 64, 2'b10 gives 372 and 2'b11 gives 256. Taking the accepting clock edge as cycle 0, the start bit spans cycles 0 to etu-1 and bit 0 of the data begins at cycle etu.
- R2: A transmitted character is the start bit (low), then `tx_data[0]` through `tx_data[7]`, then the parity slot, with each bit one etu long. The line is released from 10 etu onward.
- R3: The parity bit makes the number of ones across data and parity even when `cfg_par_odd`=0 and odd when it is 1. With `cfg_par_en`=0 the parity slot is left released (high), and received parity is not checked.
- R4: `tx_end` is 1 after reset and clears on the cycle after a character is accepted. It rises 12.5 etu plus one cycle after acceptance when `cfg_gsm`=0, and 11 etu plus one cycle after acceptance when `cfg_gsm`=1. In both modes `tx_ready` returns to 1 at 12.5 etu plus one cycle.
- R5: Outside block mode, if the line is low at 11 etu of a transmitted character, `tx_retry` pulses for one cycle and `tx_end` stays 0. The same character then starts again 13 etu plus one cycle after the previous start.
- R6: In block mode, a low line at 11 etu of a transmitted character is ignored: there is no `tx_retry` and no retransmission, and `tx_end` follows R4.
- R7: The receiver samples each bit in the middle of its etu, counted from the detected falling edge. It presents each character on `rx_data` with a one-cycle `rx_valid` pulse. `rx_par_err` is 1 only in that cycle, and only when parity is enabled and fails.
- R8: Outside block mode, a received parity error makes the block pull the line low for 1 etu, starting 10.5 etu after the start edge.
- R9: In block mode, a received parity error only sets `rx_par_err`, and the line is never driven during reception.
- R10: A falling edge whose line is high again at half an etu is not treated as a character: there is no `rx_valid`, and the engine is idle again before one etu has elapsed.
- R11: Operation is half duplex. `tx_ready` is 0 while a character is being received. The receiver ignores the line while the transmitter is busy.
- R12: `card_clk_en` is 1 when `cfg_gsm`=0. When `cfg_gsm`=1 it equals `cfg_clk_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_gsm | input | 1 | Early transmit-end and clock control mode |
| cfg_block | input | 1 | Block transfer mode (no error signalling) |
| cfg_par_en | input | 1 | Parity generation and check enable |
| cfg_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cfg_cps | input | 2 | Clock cycles per etu select |
| cfg_clk_run | input | 1 | Card clock request in GSM mode |
| tx_valid | input | 1 | Character offered for transmission |
| tx_data | input | 8 | Character to transmit |
| tx_ready | output | 1 | Engine idle, character accepted when `tx_valid` is 1 |
| tx_end | output | 1 | Transmit-end flag |
| tx_retry | output | 1 | One-cycle pulse when the card signals an error |
| rx_valid | output | 1 | One-cycle pulse with a received character |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity error of the character in `rx_valid` |
| io_line | input | 1 | Sensed level of the data line |
| io_drive_low | output | 1 | 1 pulls the data line low |
| card_clk_en | output | 1 | Card clock enable |

## Verification
The bench attacks the error handshake from both sides. A card model pulls the line low at 11 etu of a transmitted character: a design that ignores this never retransmits, and one that samples at the wrong time misses the pulse. The same pulse in block mode must be ignored, which catches a design that retransmits regardless of mode. On the receive side it injects bad parity, both with error signalling and without it, and a low glitch shorter than half an etu; a design with a missing start check delivers a phantom character. It also runs every etu select with exact-cycle probes at the start-bit boundary, so a swapped 372/256 mapping or an off-by-one counter shows up as a wrong line level.

// File: rtl/sc_pkg.sv
// Shared constants for the smart card character engine.
// All frame events are expressed in half-etu steps counted from the start bit.
package sc_pkg;
    localparam int HW = 5;                                  // width of half-etu index
    localparam logic [HW-1:0] H_START_CHK  = 5'd1;          // mid start bit
    localparam logic [HW-1:0] H_DATA_FIRST = 5'd3;          // mid data bit 0
    localparam logic [HW-1:0] H_DATA_LAST  = 5'd17;         // mid data bit 7
    localparam logic [HW-1:0] H_PAR_SMP    = 5'd19;         // mid parity bit
    localparam logic [HW-1:0] H_BITS_END   = 5'd20;         // 10 etu, line released
    localparam logic [HW-1:0] H_RX_DONE    = 5'd21;         // 10.5 etu
    localparam logic [HW-1:0] H_TX_ERR_SMP = 5'd22;         // 11 etu
    localparam logic [HW-1:0] H_ERRSIG_END = 5'd23;         // 11.5 etu
    localparam logic [HW-1:0] H_TX_DONE    = 5'd25;         // 12.5 etu
    localparam logic [HW-1:0] H_RETRY      = 5'd26;         // 13 etu
endpackage

// File: rtl/sc_half_timer.sv
// Half-etu timer: counts base clock cycles and advances a half-etu index.
// Assumes half_len >= 1 and stable while run is 1.
module sc_half_timer #(
    parameter int CW = 9,
    parameter int HW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [CW-1:0] half_len,
    output logic [HW-1:0] h,
    output logic          at_step
);
    logic [CW-1:0] cnt;

    assign at_step = (cnt == '0);

    // Advance the cycle count and the half-etu index.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
            h   <= '0;
        end else if (run) begin
            if (cnt == half_len - CW'(1)) begin
                cnt <= '0;
                h   <= h + HW'(1);
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/sc_tx.sv
// Transmit sequencer: sends start, 8 data bits LSB first and parity, then
// watches for a card error pulse at 11 etu and retransmits at 13 etu.
// Assumes line_s is already synchronised to clk.
module sc_tx #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] half_len,
    input  logic          cfg_gsm,
    input  logic          cfg_block,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          start,
    input  logic [7:0]    data,
    input  logic          line_s,
    output logic          busy,
    output logic          drive_low,
    output logic          tx_end,
    output logic          tx_retry
);
    import sc_pkg::*;

    logic [7:0]    hold;
    logic          err_seen;
    logic [HW-1:0] h;
    logic          at_step;
    logic          retry_go;
    logic          slot;
    logic [3:0]    bidx;
    logic [2:0]    didx;
    logic          par_bit;

    assign retry_go = busy && at_step && (h == H_RETRY);

    sc_half_timer #(.CW(CW), .HW(HW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(start || retry_go),
        .half_len(half_len), .h(h), .at_step(at_step)
    );

    assign bidx    = h[HW-1:1];
    assign didx    = bidx[2:0] - 3'd1;
    assign par_bit = (^hold) ^ cfg_par_odd;

    // Select the level of the current bit slot.
    always_comb begin
        slot = 1'b1;
        if (h < H_BITS_END) begin
            case (bidx)
                4'd0:    slot = 1'b0;
                4'd9:    slot = cfg_par_en ? par_bit : 1'b1;
                default: slot = hold[didx];
            endcase
        end
    end

    assign drive_low = busy && !slot;

    // Sequence acceptance, error sampling, end flag and retransmission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            hold     <= '0;
            err_seen <= 1'b0;
            tx_end   <= 1'b1;
            tx_retry <= 1'b0;
        end else begin
            tx_retry <= 1'b0;
            if (start) begin
                busy     <= 1'b1;
                hold     <= data;
                err_seen <= 1'b0;
                tx_end   <= 1'b0;
            end else if (busy && at_step) begin
                if (h == H_TX_ERR_SMP) begin
                    if (!line_s && !cfg_block) begin
                        err_seen <= 1'b1;
                        tx_retry <= 1'b1;
                    end else if (cfg_gsm) begin
                        tx_end <= 1'b1;
                    end
                end
                if (h == H_TX_DONE && !err_seen) begin
                    busy <= 1'b0;
                    if (!cfg_gsm) tx_end <= 1'b1;
                end
                if (h == H_RETRY) err_seen <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sc_rx.sv
// Receive sampler: detects a falling start edge, confirms it at half an etu,
// samples data and parity mid-bit and drives the error pulse on bad parity.
// Assumes line_s/line_prev are synchronised, consecutive line samples.
module sc_rx #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] half_len,
    input  logic          cfg_block,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          enable,
    input  logic          line_s,
    input  logic          line_prev,
    output logic          busy,
    output logic          drive_low,
    output logic          rx_valid,
    output logic [7:0]    rx_data,
    output logic          rx_par_err
);
    import sc_pkg::*;

    logic [7:0]    sh;
    logic          par_ok;
    logic          bad;
    logic          go;
    logic [HW-1:0] h;
    logic          at_step;

    assign go  = enable && !busy && line_prev && !line_s;
    assign bad = cfg_par_en && !par_ok;

    sc_half_timer #(.CW(CW), .HW(HW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(go),
        .half_len(half_len), .h(h), .at_step(at_step)
    );

    // Walk the character, deliver it and signal a parity error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            drive_low  <= 1'b0;
            sh         <= '0;
            par_ok     <= 1'b1;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_par_err <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            if (go) begin
                busy <= 1'b1;
            end else if (busy && at_step) begin
                if (h == H_START_CHK && line_s) busy <= 1'b0;
                if (h[0] && h >= H_DATA_FIRST && h <= H_DATA_LAST)
                    sh <= {line_s, sh[7:1]};
                if (h == H_PAR_SMP)
                    par_ok <= ((^sh) ^ line_s) == cfg_par_odd;
                if (h == H_RX_DONE) begin
                    rx_valid   <= 1'b1;
                    rx_data    <= sh;
                    rx_par_err <= bad;
                    if (bad && !cfg_block) drive_low <= 1'b1;
                    else                   busy      <= 1'b0;
                end
                if (h == H_ERRSIG_END) begin
                    drive_low <= 1'b0;
                    busy      <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sc_char_engine.sv
// Smart card character engine top: line synchroniser, etu select, one
// transmitter and one receiver sharing the open-drain line half duplex.
// Assumes configuration inputs are stable while a character is in flight.
module sc_char_engine #(
    parameter int ETU_00 = 32,
    parameter int ETU_01 = 64,
    parameter int ETU_10 = 372,
    parameter int ETU_11 = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_gsm,
    input  logic       cfg_block,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [1:0] cfg_cps,
    input  logic       cfg_clk_run,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       tx_end,
    output logic       tx_retry,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_par_err,
    input  logic       io_line,
    output logic       io_drive_low,
    output logic       card_clk_en
);
    localparam int MAX_A = (ETU_00 > ETU_01) ? ETU_00 : ETU_01;
    localparam int MAX_B = (ETU_10 > ETU_11) ? ETU_10 : ETU_11;
    localparam int MAX_E = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_E / 2 + 1);

    logic [CW-1:0] half_len;
    logic          sync1, line_s, line_prev;
    logic          tx_busy, rx_busy, tx_drv, rx_drv;

    // Map the etu select to half an etu of base cycles.
    always_comb begin
        case (cfg_cps)
            2'b00:   half_len = CW'(ETU_00 / 2);
            2'b01:   half_len = CW'(ETU_01 / 2);
            2'b10:   half_len = CW'(ETU_10 / 2);
            default: half_len = CW'(ETU_11 / 2);
        endcase
    end

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1     <= 1'b1;
            line_s    <= 1'b1;
            line_prev <= 1'b1;
        end else begin
            sync1     <= io_line;
            line_s    <= sync1;
            line_prev <= line_s;
        end
    end

    assign tx_ready = !tx_busy && !rx_busy;

    sc_tx #(.CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .half_len(half_len),
        .cfg_gsm(cfg_gsm), .cfg_block(cfg_block),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .start(tx_valid && tx_ready), .data(tx_data), .line_s(line_s),
        .busy(tx_busy), .drive_low(tx_drv), .tx_end(tx_end), .tx_retry(tx_retry)
    );

    sc_rx #(.CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .half_len(half_len),
        .cfg_block(cfg_block), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .enable(!tx_busy), .line_s(line_s), .line_prev(line_prev),
        .busy(rx_busy), .drive_low(rx_drv), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_par_err(rx_par_err)
    );

    assign io_drive_low = tx_drv || rx_drv;
    assign card_clk_en  = !cfg_gsm || cfg_clk_run;
endmodule

// File: rtl/sc_char_engine_chk.sv
// Property checker for sc_char_engine, attached with bind below.
module sc_char_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_gsm,
    input logic cfg_block,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_end,
    input logic rx_valid,
    input logic rx_par_err,
    input logic io_drive_low,
    input logic card_clk_en,
    input logic tx_busy,
    input logic rx_busy,
    input logic rx_drv
);
    AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && rx_busy)); // R11
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !io_drive_low); // R11
    AST_TXEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_end); // R4
    AST_RXVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
    AST_PERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_par_err |-> rx_valid); // R7
    AST_BLOCK_NO_ERRSIG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_block && $past(cfg_block)) |-> !rx_drv); // R9
    AST_CLK_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_gsm |-> card_clk_en); // R12
endmodule

bind sc_char_engine sc_char_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_gsm(cfg_gsm), .cfg_block(cfg_block),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_end(tx_end),
    .rx_valid(rx_valid), .rx_par_err(rx_par_err), .io_drive_low(io_drive_low),
    .card_clk_en(card_clk_en), .tx_busy(tx_busy), .rx_busy(rx_busy), .rx_drv(rx_drv)
);

// File: tb/tb_sc_char_engine.sv
// Scoreboard bench: card_send pushes expected characters, a monitor pops them
// on rx_valid; transmit characters are decoded from the line by a card model.
module tb_sc_char_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_gsm = 1'b0, cfg_block = 1'b0, cfg_par_en = 1'b1, cfg_par_odd = 1'b0;
    logic [1:0] cfg_cps = 2'b00;
    logic       cfg_clk_run = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready, tx_end, tx_retry, rx_valid, rx_par_err;
    logic [7:0] rx_data;
    logic       io_drive_low, card_clk_en;
    logic       card_low = 1'b0;
    wire        io_line = !(io_drive_low || card_low);

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [8:0] sbq[$];

    always #10 clk = !clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sc_char_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_gsm(cfg_gsm), .cfg_block(cfg_block),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_cps(cfg_cps),
        .cfg_clk_run(cfg_clk_run), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_end(tx_end), .tx_retry(tx_retry),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .io_line(io_line), .io_drive_low(io_drive_low), .card_clk_en(card_clk_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int etu();
        case (cfg_cps)
            2'b00:   return 32;
            2'b01:   return 64;
            2'b10:   return 372;
            default: return 256;
        endcase
    endfunction

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // Monitor: pop the expected character on every rx_valid.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_valid) begin
                if (sbq.size() == 0) begin
                    chk(0, "R7/R10/R11 unexpected rx_valid", rx_data, 0);
                end else begin
                    logic [8:0] e;
                    e = sbq.pop_front();
                    chk(rx_data == e[7:0], "R7 rx data", rx_data, e[7:0]);
                    chk(rx_par_err == e[8], "R7/R9 rx parity flag", rx_par_err, e[8]);
                end
            end
        end
    end

    // DUT transmits d; card model decodes it, optionally pulling low at 11 etu.
    task automatic dut_tx(input logic [7:0] d, input bit nack);
        int e;
        int t0;
        logic [9:0] bits;
        logic pexp;
        bit retry;
        e = etu();
        retry = nack && !cfg_block;
        pexp = cfg_par_en ? ((^d) ^ cfg_par_odd) : 1'b1;
        chk(tx_ready == 1'b1, "R11 ready before tx", tx_ready, 1);
        tx_valid = 1'b1;
        tx_data  = d;
        @(negedge clk);
        t0 = cyc;
        tx_valid = 1'b0;
        chk(tx_end == 1'b0, "R4 tx_end cleared on accept", tx_end, 0);
        for (int a = 0; a < 2; a++) begin
            wait_until(t0 + e / 2);
            bits[0] = io_line;
            wait_until(t0 + e - 1);
            chk(io_line == 1'b0, "R1 start bit still low at etu-1", io_line, 0);
            wait_until(t0 + e);
            chk(io_line == d[0], "R1 data bit 0 begins at etu", io_line, d[0]);
            for (int i = 1; i < 10; i++) begin
                wait_until(t0 + i * e + e / 2);
                bits[i] = io_line;
            end
            chk(bits[0] == 1'b0, "R2 start bit", bits[0], 0);
            chk(bits[8:1] == d, "R2 data LSB first", bits[8:1], d);
            chk(bits[9] == pexp, "R3 parity slot", bits[9], pexp);
            wait_until(t0 + 10 * e + e / 2);
            chk(io_line == 1'b1, "R2 line released after 10 etu", io_line, 1);
            if (nack && a == 0) begin
                card_low = 1'b1;
                wait_until(t0 + 11 * e + 1);
                chk(tx_retry == retry, retry ? "R5 tx_retry pulse" : "R6 block ignores error",
                    tx_retry, retry);
                chk(tx_end == 1'b0, "R5 no tx_end on error", tx_end, 0);
                wait_until(t0 + 11 * e + e / 2);
                card_low = 1'b0;
                if (retry) begin
                    t0 = t0 + 13 * e + 1;
                    continue;
                end
            end
            break;
        end
        if (cfg_gsm) begin
            wait_until(t0 + 11 * e);
            chk(tx_end == 1'b0, "R4 gsm tx_end not before 11 etu", tx_end, 0);
            wait_until(t0 + 11 * e + 1);
            chk(tx_end == 1'b1, "R4 gsm tx_end at 11 etu", tx_end, 1);
        end else begin
            wait_until(t0 + 12 * e + e / 2);
            chk(tx_end == 1'b0, "R4 tx_end not before 12.5 etu", tx_end, 0);
            wait_until(t0 + 12 * e + e / 2 + 1);
            chk(tx_end == 1'b1, "R4 tx_end at 12.5 etu", tx_end, 1);
        end
        wait_until(t0 + 12 * e + e / 2 + 1);
        chk(tx_ready == 1'b1, "R4 ready at 12.5 etu", tx_ready, 1);
    endtask

    // Card sends d (bad flips the parity bit); expectation goes to the scoreboard.
    task automatic card_send(input logic [7:0] d, input bit bad);
        int e;
        int t0;
        bit perr;
        bit errsig;
        e = etu();
        perr   = cfg_par_en && bad;
        errsig = perr && !cfg_block;
        sbq.push_back({perr, d});
        t0 = cyc;
        card_low = 1'b1;
        for (int i = 1; i < 9; i++) begin
            wait_until(t0 + i * e);
            card_low = !d[i-1];
            if (i == 5) chk(tx_ready == 1'b0, "R11 not ready while receiving", tx_ready, 0);
        end
        wait_until(t0 + 9 * e);
        card_low = !(((^d) ^ cfg_par_odd) ^ bad);
        wait_until(t0 + 10 * e);
        card_low = 1'b0;
        wait_until(t0 + 11 * e);
        chk(io_line == !errsig, errsig ? "R8 error signal driven" : "R9 no error signal",
            io_line, !errsig);
        wait_until(t0 + 13 * e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R4 reset ready", tx_ready, 1);
        chk(tx_end == 1'b1, "R4 reset tx_end", tx_end, 1);
        chk(io_drive_low == 1'b0, "R2 reset line released", io_drive_low, 0);
        chk(rx_valid == 1'b0, "R7 reset no rx_valid", rx_valid, 0);

        dut_tx(8'hA5, 1'b0);
        cfg_par_odd = 1'b1; dut_tx(8'h3C, 1'b0); cfg_par_odd = 1'b0;
        cfg_par_en = 1'b0;  dut_tx(8'h81, 1'b0); cfg_par_en = 1'b1;
        cfg_gsm = 1'b1; dut_tx(8'h5A, 1'b0); dut_tx(8'h11, 1'b1); cfg_gsm = 1'b0;
        dut_tx(8'hC3, 1'b1);
        cfg_block = 1'b1; dut_tx(8'h77, 1'b1); cfg_block = 1'b0;

        card_send(8'h96, 1'b0);
        card_send(8'h4D, 1'b1);
        cfg_par_odd = 1'b1; card_send(8'hE1, 1'b0); card_send(8'h0F, 1'b1); cfg_par_odd = 1'b0;
        cfg_par_en = 1'b0;  card_send(8'h2B, 1'b1); cfg_par_en = 1'b1;
        cfg_block = 1'b1;   card_send(8'hB4, 1'b1); cfg_block = 1'b0;

        begin : glitch_r10
            int t0;
            t0 = cyc;
            card_low = 1'b1;
            wait_until(t0 + 4);
            card_low = 1'b0;
            wait_until(t0 + 32);
            chk(tx_ready == 1'b1, "R10 false start rejected", tx_ready, 1);
            wait_until(t0 + 64);
        end
        card_send(8'h12, 1'b0);

        for (int s = 1; s < 4; s++) begin
            cfg_cps = 2'(s);
            @(negedge clk);
            dut_tx(8'h01 + 8'(s), 1'b0);
        end
        cfg_cps = 2'b10; card_send(8'h6E, 1'b1);
        cfg_cps = 2'b00;

        chk(card_clk_en == 1'b1, "R12 clock enabled outside gsm", card_clk_en, 1);
        cfg_gsm = 1'b1; @(negedge clk);
        chk(card_clk_en == 1'b0, "R12 gsm clock stopped", card_clk_en, 0);
        cfg_clk_run = 1'b1; @(negedge clk);
        chk(card_clk_en == 1'b1, "R12 gsm clock running", card_clk_en, 1);
        cfg_gsm = 1'b0; cfg_clk_run = 1'b0;

        repeat (10) @(negedge clk);
        chk(sbq.size() == 0, "R7 all characters received", sbq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule